// File: doc/BRIEF.md
# Programmable FIFO Interrupt Trigger Unit

This block decides when a UART channel raises its two FIFO-driven interrupt requests. One is the transmit request, which asks for more characters. The other is the receive data-available request. Each cycle the block compares the transmit and receive FIFO fill counts against a pair of thresholds. Depending on a mode input, those thresholds come either from two freely programmable 7-bit registers or from a small set of fixed legacy levels, which a two-bit code selects.

In programmable mode, a transmit threshold of zero does not mean "below zero", which could never happen. Instead it selects a fully-drained condition. The transmit request then fires only once the FIFO is empty, the shift register has sent its last bit and the serial line rests in the idle mark state. Software uses this to learn that the transmitter has really finished.

Both requests are registered and come with a priority code. The interrupt identification logic downstream uses this code; a lower number wins. Clearing a request is not an action of this block. A request drops when its condition is false at the next clock edge.

Top module: `uart_trig_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `tx_irq` and `rx_irq` are 0 and `irq_prio` is 0.
- R2: Every output reflects the inputs sampled at the previous rising clock edge (one register stage); an input change is not visible before that edge.
- R3: With `enh_en`=1 and `tx_thr`≠0, `tx_irq` is 1 exactly when `tx_ie`=1 and `tx_level` < `tx_thr`.
- R4: With `enh_en`=1 and `tx_thr`=0, `tx_irq` is 1 exactly when `tx_ie`=1, `tx_level`=0, `tx_shift_empty`=1 and `line_idle`=1.
- R5: With `enh_en`=1, `rx_irq` is 1 exactly when `rx_ie`=1 and `rx_level` ≥ `rx_thr`, so a threshold of 0 fires on any level.
- R6: A request whose mask bit (`tx_ie` or `rx_ie`) is 0 stays 0 whatever the levels and thresholds.
- R7: With `enh_en`=0, the receive trigger level is set by `rx_sel`: 0→16, 1→32, 2→112, 3→120 for a 128-deep FIFO. `rx_irq` is 1 when `rx_ie`=1 and `rx_level` ≥ that level, and `rx_thr` has no effect.
- R8: With `enh_en`=0, the transmit trigger level is set by `tx_sel`: 0→16, 1→32, 2→64, 3→112. `tx_irq` is 1 when `tx_ie`=1 and `tx_level` < that level. `tx_thr`, `tx_shift_empty` and `line_idle` have no effect.
- R9: With `enh_en`=1, `tx_sel` and `rx_sel` have no effect on either request.
- R10: `irq_prio` is 2 when `rx_irq` is 1, is 3 when only `tx_irq` is 1, and is 0 when neither is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enh_en | input | 1 | 1 = programmable thresholds, 0 = legacy fixed levels |
| tx_ie | input | 1 | Transmit request mask (1 = enabled) |
| rx_ie | input | 1 | Receive request mask (1 = enabled) |
| tx_sel | input | 2 | Legacy transmit level select |
| rx_sel | input | 2 | Legacy receive level select |
| tx_thr | input | 7 | Programmable transmit threshold |
| rx_thr | input | 7 | Programmable receive threshold |
| tx_level | input | 8 | Transmit FIFO fill count (0..128) |
| rx_level | input | 8 | Receive FIFO fill count (0..128) |
| tx_shift_empty | input | 1 | Transmit shift register holds no data |
| line_idle | input | 1 | Serial output sits at idle mark |
| tx_irq | output | 1 | Transmit request |
| rx_irq | output | 1 | Receive data-available request |
| irq_prio | output | 2 | Code of the highest pending request (2, 3, or 0) |

## Verification
The bench sweeps each fill count through its threshold, including the values just below, at and above it. An off-by-one comparison shows up there as a request that appears or vanishes one level early. The zero transmit threshold is tried with the shift register busy, with the line not idle and with one character left. A design that treated zero as an ordinary threshold would never fire, and one that skipped a qualifier would fire early. In legacy mode, every select code is swept while the programmable registers are set to misleading values. In programmable mode, the select codes are toggled. Either mix-up shows up as a shifted trigger point. Cases with both requests pending make sure a priority encoder with the order inverted reports 3 instead of 2.

// File: rtl/uart_trig_pkg.sv
package uart_trig_pkg;

  typedef enum logic [1:0] {
    PRIO_NONE = 2'd0,
    PRIO_RX   = 2'd2,
    PRIO_TX   = 2'd3
  } trig_prio_e;

  // Legacy receive level as a fraction of the FIFO depth.
  function automatic int unsigned legacy_rx_level(input int unsigned depth,
                                                  input logic [1:0] sel);
    case (sel)
      2'd0:    return depth / 8;
      2'd1:    return depth / 4;
      2'd2:    return (depth * 7) / 8;
      default: return (depth * 15) / 16;
    endcase
  endfunction

  // Legacy transmit level as a fraction of the FIFO depth.
  function automatic int unsigned legacy_tx_level(input int unsigned depth,
                                                  input logic [1:0] sel);
    case (sel)
      2'd0:    return depth / 8;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return (depth * 7) / 8;
    endcase
  endfunction

  // Fill count has reached the trigger.
  function automatic logic reached(input int unsigned level, input int unsigned trig);
    return level >= trig;
  endfunction

  // Fill count is strictly below the trigger.
  function automatic logic below(input int unsigned level, input int unsigned trig);
    return level < trig;
  endfunction

  function automatic trig_prio_e encode_prio(input logic rx_req, input logic tx_req);
    if (rx_req)      return PRIO_RX;
    else if (tx_req) return PRIO_TX;
    else             return PRIO_NONE;
  endfunction

endpackage

// File: rtl/trig_level_sel.sv
module trig_level_sel
  import uart_trig_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int THR_W = 7,
  parameter int LVL_W = $clog2(DEPTH + 1),
  parameter bit IS_RX = 1'b0
) (
  input  logic             enh_en,
  input  logic [1:0]       sel,
  input  logic [THR_W-1:0] thr,
  output logic [LVL_W-1:0] eff_trig,
  output logic             drain_mode
);

  logic [LVL_W-1:0] legacy_trig;

  generate
    if (IS_RX) begin : g_rx
      always_comb legacy_trig = LVL_W'(legacy_rx_level(DEPTH, sel));
      assign drain_mode = 1'b0;
    end else begin : g_tx
      always_comb legacy_trig = LVL_W'(legacy_tx_level(DEPTH, sel));
      assign drain_mode = enh_en && (thr == '0);
    end
  endgenerate

  always_comb begin
    if (enh_en) eff_trig = LVL_W'(thr);
    else        eff_trig = legacy_trig;
  end

endmodule

// File: rtl/trig_tx_cond.sv
module trig_tx_cond
  import uart_trig_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic             ie,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] eff_trig,
  input  logic             drain_mode,
  input  logic             shift_empty,
  input  logic             line_idle,
  output logic             cond
);

  logic drained;
  logic under;

  assign drained = (level == '0) && shift_empty && line_idle;
  assign under   = below(int'(level), int'(eff_trig));

  always_comb begin
    if (!ie)             cond = 1'b0;
    else if (drain_mode) cond = drained;
    else                 cond = under;
  end

endmodule

// File: rtl/trig_rx_cond.sv
module trig_rx_cond
  import uart_trig_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic             ie,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] eff_trig,
  output logic             cond
);

  assign cond = ie && reached(int'(level), int'(eff_trig));

endmodule

// File: rtl/uart_trig_unit.sv
module uart_trig_unit
  import uart_trig_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int THR_W = 7,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enh_en,
  input  logic             tx_ie,
  input  logic             rx_ie,
  input  logic [1:0]       tx_sel,
  input  logic [1:0]       rx_sel,
  input  logic [THR_W-1:0] tx_thr,
  input  logic [THR_W-1:0] rx_thr,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_shift_empty,
  input  logic             line_idle,
  output logic             tx_irq,
  output logic             rx_irq,
  output logic [1:0]       irq_prio
);

  // Named internal events, visible to the checker.
  logic [LVL_W-1:0] tx_trig_w;
  logic [LVL_W-1:0] rx_trig_w;
  logic             tx_drain_w;
  logic             rx_drain_unused;
  logic             tx_cond_w;
  logic             rx_cond_w;
  trig_prio_e       prio_next_w;

  trig_level_sel #(.DEPTH(DEPTH), .THR_W(THR_W), .LVL_W(LVL_W), .IS_RX(1'b0)) u_tx_sel (
    .enh_en(enh_en), .sel(tx_sel), .thr(tx_thr),
    .eff_trig(tx_trig_w), .drain_mode(tx_drain_w)
  );

  trig_level_sel #(.DEPTH(DEPTH), .THR_W(THR_W), .LVL_W(LVL_W), .IS_RX(1'b1)) u_rx_sel (
    .enh_en(enh_en), .sel(rx_sel), .thr(rx_thr),
    .eff_trig(rx_trig_w), .drain_mode(rx_drain_unused)
  );

  trig_tx_cond #(.LVL_W(LVL_W)) u_tx_cond (
    .ie(tx_ie), .level(tx_level), .eff_trig(tx_trig_w), .drain_mode(tx_drain_w),
    .shift_empty(tx_shift_empty), .line_idle(line_idle), .cond(tx_cond_w)
  );

  trig_rx_cond #(.LVL_W(LVL_W)) u_rx_cond (
    .ie(rx_ie), .level(rx_level), .eff_trig(rx_trig_w), .cond(rx_cond_w)
  );

  assign prio_next_w = encode_prio(rx_cond_w, tx_cond_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_irq   <= 1'b0;
      rx_irq   <= 1'b0;
      irq_prio <= PRIO_NONE;
    end else begin
      tx_irq   <= tx_cond_w;
      rx_irq   <= rx_cond_w;
      irq_prio <= prio_next_w;
    end
  end

endmodule

// File: rtl/uart_trig_chk.sv
module uart_trig_chk #(
  parameter int THR_W = 7,
  parameter int LVL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enh_en,
  input logic             tx_ie,
  input logic             rx_ie,
  input logic [THR_W-1:0] tx_thr,
  input logic [THR_W-1:0] rx_thr,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             tx_shift_empty,
  input logic             line_idle,
  input logic             tx_irq,
  input logic             rx_irq,
  input logic [1:0]       irq_prio
);

  AST_TX_BELOW_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_en && tx_ie && tx_thr != '0 && tx_level < LVL_W'(tx_thr)) |=> tx_irq); // R3

  AST_TX_AT_THR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_en && tx_thr != '0 && tx_level >= LVL_W'(tx_thr)) |=> !tx_irq); // R3

  AST_TX_DRAIN_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_en && tx_thr == '0 && (tx_level != '0 || !tx_shift_empty || !line_idle)) |=> !tx_irq); // R4

  AST_TX_DRAIN_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_en && tx_ie && tx_thr == '0 && tx_level == '0 && tx_shift_empty && line_idle) |=> tx_irq); // R4

  AST_RX_REACHED: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_en && rx_ie && rx_level >= LVL_W'(rx_thr)) |=> rx_irq); // R5

  AST_RX_SHORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_en && rx_level < LVL_W'(rx_thr)) |=> !rx_irq); // R5

  AST_TX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ie |=> !tx_irq); // R6

  AST_RX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ie |=> !rx_irq); // R6

  AST_PRIO_RX: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> irq_prio == 2'd2); // R10

  AST_PRIO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && !rx_irq) |-> irq_prio == 2'd3); // R10

  AST_PRIO_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_irq && !rx_irq) |-> irq_prio == 2'd0); // R10

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (!tx_irq && !rx_irq && irq_prio == 2'd0)); // R1

endmodule

bind uart_trig_unit uart_trig_chk #(.THR_W(THR_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enh_en(enh_en), .tx_ie(tx_ie), .rx_ie(rx_ie),
  .tx_thr(tx_thr), .rx_thr(rx_thr), .tx_level(tx_level), .rx_level(rx_level),
  .tx_shift_empty(tx_shift_empty), .line_idle(line_idle),
  .tx_irq(tx_irq), .rx_irq(rx_irq), .irq_prio(irq_prio)
);

// File: tb/sim_uart_trig_unit.sv
`timescale 1ns/1ps
module sim_uart_trig_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enh_en = 1'b0, tx_ie = 1'b0, rx_ie = 1'b0;
  logic [1:0] tx_sel = '0, rx_sel = '0;
  logic [6:0] tx_thr = '0, rx_thr = '0;
  logic [7:0] tx_level = '0, rx_level = '0;
  logic       tx_shift_empty = 1'b1, line_idle = 1'b1;
  logic       tx_irq, rx_irq;
  logic [1:0] irq_prio;

  int n_checks = 0;
  int n_fail   = 0;
  string phase = "R1";
  bit   exp_tx = 0, exp_rx = 0;
  int   exp_prio = 0;
  int   rx_tab[4] = '{16, 32, 112, 120};
  int   tx_tab[4] = '{16, 32, 64, 112};

  always #4 clk = ~clk;  // 125 MHz

  uart_trig_unit u0 (
    .clk(clk), .rst_n(rst_n), .enh_en(enh_en), .tx_ie(tx_ie), .rx_ie(rx_ie),
    .tx_sel(tx_sel), .rx_sel(rx_sel), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .tx_level(tx_level), .rx_level(rx_level), .tx_shift_empty(tx_shift_empty),
    .line_idle(line_idle), .tx_irq(tx_irq), .rx_irq(rx_irq), .irq_prio(irq_prio)
  );

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model: evaluated from the inputs present at the rising edge.
  task automatic model();
    int tl, rl;
    if (!rst_n) begin
      exp_tx = 0; exp_rx = 0; exp_prio = 0;
      return;
    end
    tl = tx_level; rl = rx_level;
    if (enh_en) begin
      if (tx_thr == 0) exp_tx = tx_ie && tl == 0 && tx_shift_empty && line_idle;
      else             exp_tx = tx_ie && tl < int'(tx_thr);
      exp_rx = rx_ie && rl >= int'(rx_thr);
    end else begin
      exp_tx = tx_ie && tl < tx_tab[tx_sel];
      exp_rx = rx_ie && rl >= rx_tab[rx_sel];
    end
    exp_prio = exp_rx ? 2 : (exp_tx ? 3 : 0);
  endtask

  // One cycle: model at the edge, compare at the falling edge.
  task automatic tick();
    @(posedge clk);
    #1 model();
    @(negedge clk);
    check(phase, "tx_irq", tx_irq, exp_tx);
    check(phase, "rx_irq", rx_irq, exp_rx);
    check((phase == "R1") ? "R1" : "R10", "irq_prio", irq_prio, exp_prio);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // R1: reset
    @(negedge clk);
    phase = "R1";
    tx_ie = 1; rx_ie = 1; rx_level = 128;
    tick(); tick();
    check("R1", "tx_irq in reset", tx_irq, 0);
    check("R1", "rx_irq in reset", rx_irq, 0);
    rst_n = 1;
    tick();
    tx_ie = 0; rx_ie = 0; rx_level = 0;
    tick();

    // R3: transmit sweep through a programmable threshold
    phase = "R3";
    enh_en = 1; tx_ie = 1; tx_thr = 40;
    for (int l = 0; l <= 128; l++) begin tx_level = 8'(l); tick(); end
    tx_thr = 1;
    for (int l = 0; l <= 3; l++) begin tx_level = 8'(l); tick(); end
    tx_thr = 127;
    for (int l = 125; l <= 128; l++) begin tx_level = 8'(l); tick(); end

    // R2: a change is seen only after the next edge
    phase = "R2";
    tx_thr = 40; tx_level = 50; tick();
    @(negedge clk);
    tx_level = 10; #2;
    check("R2", "tx_irq before edge", tx_irq, 0);
    tick();

    // R4: drained mode with zero threshold
    phase = "R4";
    tx_thr = 0; tx_level = 0; tx_shift_empty = 0; line_idle = 0; tick(); tick();
    line_idle = 1; tick();
    tx_shift_empty = 1; line_idle = 0; tick();
    line_idle = 1; tick(); tick();
    tx_level = 1; tick();
    tx_level = 0; tx_shift_empty = 0; tick();
    tx_shift_empty = 1; tick();

    // R5: receive sweep
    phase = "R5";
    rx_ie = 1; rx_thr = 50;
    for (int l = 0; l <= 128; l++) begin rx_level = 8'(l); tick(); end
    rx_thr = 127;
    for (int l = 125; l <= 128; l++) begin rx_level = 8'(l); tick(); end
    rx_thr = 0; rx_level = 0; tick();

    // R6: masks
    phase = "R6";
    tx_ie = 0; rx_ie = 0; tx_thr = 100; tx_level = 0; rx_thr = 1; rx_level = 128; tick(); tick();
    tx_thr = 0; tx_shift_empty = 1; line_idle = 1; tick();
    enh_en = 0; tick();
    check("R6", "tx masked", tx_irq, 0);
    check("R6", "rx masked", rx_irq, 0);
    tx_ie = 1; rx_ie = 1; enh_en = 1;

    // R7: legacy receive levels, programmable register set misleadingly
    phase = "R7";
    enh_en = 0; rx_thr = 1; tx_level = 128;
    for (int s = 0; s < 4; s++) begin
      rx_sel = 2'(s);
      for (int d = -2; d <= 2; d++) begin rx_level = 8'(rx_tab[s] + d); tick(); end
    end
    rx_level = 0;

    // R8: legacy transmit levels, zero threshold and drained flags misleading
    phase = "R8";
    tx_thr = 0; tx_shift_empty = 0; line_idle = 0;
    for (int s = 0; s < 4; s++) begin
      tx_sel = 2'(s);
      for (int d = -2; d <= 2; d++) begin tx_level = 8'(tx_tab[s] + d); tick(); end
    end
    tx_level = 0; tick();

    // R9: legacy selects ignored in programmable mode
    phase = "R9";
    enh_en = 1; tx_thr = 20; rx_thr = 60; tx_level = 19; rx_level = 59;
    for (int s = 0; s < 4; s++) begin tx_sel = 2'(s); rx_sel = 2'(3 - s); tick(); end
    tx_level = 20; rx_level = 60;
    for (int s = 0; s < 4; s++) begin tx_sel = 2'(s); rx_sel = 2'(s); tick(); end

    // R10: priority with both, one, or none pending
    phase = "R10";
    tx_level = 0; rx_level = 100; tick();
    check("R10", "prio both pending", irq_prio, 2);
    rx_level = 0; tick();
    check("R10", "prio tx only", irq_prio, 3);
    tx_level = 50; tick();
    check("R10", "prio none", irq_prio, 0);
    rx_level = 70; tick();
    tx_level = 5; tick();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule